// File: doc/BRIEF.md
# Serial Gain-Control Update Sequencer

This block holds four 8-bit gain settings, one for each profile. It tracks which setting is in force, given by two profile-select bits in a control register and an external profile pin. When that effective gain changes, it sends the new value to an external amplifier over a 3-wire serial link made of an active-low enable, a serial clock and a data line. A change can come from a hardware reset, a software reset, a profile change or a register write.

The value must first hold steady for a fixed quiet period. If it changes again during that period, the wait starts over, so only the settled value is sent. A frame that has started always runs to the end. A change that arrives during a frame is handled after the frame closes, with a fresh quiet period. No frame is sent when the settled value equals the value last sent.

Top module: `gain_serial_seq`

## Requirements
- R1: While `rst_n` is low and after its release, all four gain settings are 0, `ser_en_n` is high, and `ser_clk` and `ser_data` are low. A frame carrying 0x00 follows, with `ser_en_n` falling 48 to 64 cycles after reset release.
- R2: A write to address 0x00 with data bit 5 set is a software reset. It clears all four gain settings and the two profile-select bits to 0.
- R3: After a software reset, a frame of 0x00 is sent only when the last value sent was non-zero. Otherwise no frame follows.
- R4: The profile-select bits are data bits [1:0] of a write to address 0x00. The profile pin passes through two synchronising flops. The active profile index is {sel[1], sel[0] XOR pin}, and the value sent is the gain setting of that profile.
- R5: The gain settings of profiles 0, 1, 2 and 3 are written at addresses 0x13, 0x17, 0x1B and 0x1F. A write to the setting of a profile that is not active starts no frame.
- R6: `ser_en_n` falls 57 cycles after the clock edge that captures a gain write, which is inside the 48 to 64 cycle window. A further change during the wait restarts the wait, so one frame carries only the final value.
- R7: A started frame is never cut short. A change made during a frame is sent in a later frame, after a new quiet period.
- R8: Frame format: `ser_en_n` is low for 76 cycles in total. It goes low 8 cycles before the first rising edge of `ser_clk`. There are 8 bits, MSB first. `ser_clk` is high for 4 cycles and low for 4 cycles per bit. `ser_data` changes only while `ser_clk` is low. There are 8 cycles of hold after the last bit, and `ser_clk` idles low.
- R9: From the triggering write to `ser_en_n` returning high takes no more than 200 cycles.
- R10: A write that leaves the active gain equal to the value last sent starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Synchronous active-low hardware reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 8 | Register write data |
| prof_pin | input | 1 | External profile pin, asynchronous |
| ser_en_n | output | 1 | Serial enable, active low |
| ser_clk | output | 1 | Serial clock |
| ser_data | output | 1 | Serial data, MSB first |

## Verification
The bench covers each source of gain change on its own:
- **Reset and single write.** The bench checks the exact frame timing and the bit pattern.
- **Inactive-profile write, then pin or select change.** This shows whether the profile index is formed from both sources.
- **Two writes inside the quiet period.** This distinguishes a restarting wait from one that samples early.
- **A write in the middle of a frame.** This shows whether a frame is aborted or the change is dropped instead of deferred.
- **Repeated same-value writes and back-to-back software resets.** These expose spurious frames.

// File: rtl/gsq_pkg.sv
// Shared types for the serial gain-control sequencer.
// Assumes: nothing beyond standard SystemVerilog.
package gsq_pkg;
    typedef enum logic [2:0] {
        SH_IDLE,
        SH_SETUP,
        SH_HIGH,
        SH_LOW,
        SH_HOLD
    } sh_state_t;
endpackage

// File: rtl/gsq_regs.sv
// Gain register file, control register and profile resolution.
// Holds one gain setting per profile and the profile-select bits, handles the
// software reset, synchronises the profile pin and presents the gain of the
// active profile. Assumes wr_* are synchronous to clk.
module gsq_regs #(
    parameter int GAIN_W    = 8,
    parameter int ADDR_W    = 8,
    parameter int PROF_N    = 4,
    parameter int GAIN_BASE = 'h13,
    parameter int GAIN_STEP = 4,
    parameter int CTRL_ADDR = 'h00,
    parameter int SWRST_BIT = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [GAIN_W-1:0] wr_data,
    input  logic              prof_pin,
    output logic [GAIN_W-1:0] target
);
    localparam int PROF_W = $clog2(PROF_N);

    logic [1:0]        pin_sync;
    logic [PROF_W-1:0] sel_q;
    logic [PROF_W-1:0] act_idx;
    logic              ctrl_wr;
    logic              sw_rst;
    logic [GAIN_W-1:0] gain_q [PROF_N];

    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(CTRL_ADDR));
    assign sw_rst  = ctrl_wr && wr_data[SWRST_BIT];

    // Two-flop synchroniser for the asynchronous profile pin.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_sync <= '0;
        else        pin_sync <= {pin_sync[0], prof_pin};
    end

    // Profile-select bits: loaded by a control write, cleared by software reset.
    always_ff @(posedge clk) begin
        if (!rst_n)       sel_q <= '0;
        else if (sw_rst)  sel_q <= '0;
        else if (ctrl_wr) sel_q <= wr_data[PROF_W-1:0];
    end

    // One gain setting per profile, each decoded at its own address.
    for (genvar g = 0; g < PROF_N; g++) begin : g_gain
        always_ff @(posedge clk) begin
            if (!rst_n)      gain_q[g] <= '0;
            else if (sw_rst) gain_q[g] <= '0;
            else if (wr_en && wr_addr == ADDR_W'(GAIN_BASE + g*GAIN_STEP))
                gain_q[g] <= wr_data;
        end
    end

    // Active profile from the select bits with the pin folded into bit 0.
    always_comb begin
        act_idx    = sel_q;
        act_idx[0] = sel_q[0] ^ pin_sync[1];
        target     = gain_q[act_idx];
    end

    // A software reset leaves the active gain and the select bits at zero.
    assert_swreset_clears_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sw_rst |=> (sel_q == '0) && (gain_q[0] == '0) && (gain_q[PROF_N-1] == '0));
endmodule

// File: rtl/gsq_stable.sv
// Stability detector and update decision.
// Restarts a quiet-period counter whenever the active gain changes. Once the
// value has held for STABLE_CYC cycles and differs from the value last sent
// (or a hardware-reset frame is owed), it issues a one-cycle start. While a
// frame runs, the counter is held, so a later change gets a full new wait.
module gsq_stable #(
    parameter int GAIN_W     = 8,
    parameter int STABLE_CYC = 56
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [GAIN_W-1:0] target,
    input  logic              busy,
    output logic              start
);
    localparam int CNT_W = $clog2(STABLE_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(STABLE_CYC - 1);

    logic [GAIN_W-1:0] target_q;
    logic [GAIN_W-1:0] sent_q;
    logic [CNT_W-1:0]  cnt;
    logic              force_q;

    assign start = !busy && (cnt == LAST) && (target == target_q)
                   && ((target != sent_q) || force_q);

    // Quiet-period counter, last-sent value and owed reset frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            target_q <= '0;
            sent_q   <= '0;
            cnt      <= '0;
            force_q  <= 1'b1;
        end else if (busy || start) begin
            cnt      <= '0;
            target_q <= target;
            if (start) begin
                sent_q  <= target;
                force_q <= 1'b0;
            end
        end else if (target != target_q) begin
            cnt      <= '0;
            target_q <= target;
        end else if (cnt != LAST) begin
            cnt <= cnt + 1'b1;
        end
    end

    // A start never coincides with a gain change in the same cycle.
    assert_start_on_settled_R6: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> $past(target) == target_q);
endmodule

// File: rtl/gsq_shifter.sv
// Serial frame generator.
// On start, drops the enable, waits the setup time, then shifts GAIN_W bits
// MSB first with fixed high/low half-periods, holds, and releases the enable.
// Assumes start is only raised while busy is low.
module gsq_shifter
    import gsq_pkg::*;
#(
    parameter int GAIN_W    = 8,
    parameter int SETUP_CYC = 8,
    parameter int HALF_CYC  = 4,
    parameter int HOLD_CYC  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [GAIN_W-1:0] value,
    output logic              busy,
    output logic              ser_en_n,
    output logic              ser_clk,
    output logic              ser_data
);
    localparam int MAXC  = (SETUP_CYC > HOLD_CYC) ?
                           ((SETUP_CYC > HALF_CYC) ? SETUP_CYC : HALF_CYC) :
                           ((HOLD_CYC > HALF_CYC) ? HOLD_CYC : HALF_CYC);
    localparam int CNT_W = $clog2(MAXC + 1);
    localparam int BIT_W = $clog2(GAIN_W);

    sh_state_t         state;
    logic [CNT_W-1:0]  cnt;
    logic [BIT_W-1:0]  bit_idx;
    logic [GAIN_W-1:0] sh;

    // Frame sequencing: setup, high/low per bit, hold, back to idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= SH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            sh      <= '0;
        end else begin
            case (state)
                SH_IDLE: if (start) begin
                    state   <= SH_SETUP;
                    sh      <= value;
                    cnt     <= '0;
                    bit_idx <= '0;
                end
                SH_SETUP: if (cnt == CNT_W'(SETUP_CYC - 1)) begin
                    state <= SH_HIGH;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                SH_HIGH: if (cnt == CNT_W'(HALF_CYC - 1)) begin
                    cnt <= '0;
                    if (bit_idx == BIT_W'(GAIN_W - 1)) state <= SH_HOLD;
                    else begin
                        state   <= SH_LOW;
                        sh      <= sh << 1;
                        bit_idx <= bit_idx + 1'b1;
                    end
                end else cnt <= cnt + 1'b1;
                SH_LOW: if (cnt == CNT_W'(HALF_CYC - 1)) begin
                    state <= SH_HIGH;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                SH_HOLD: if (cnt == CNT_W'(HOLD_CYC - 1)) begin
                    state <= SH_IDLE;
                    cnt   <= '0;
                end else cnt <= cnt + 1'b1;
                default: state <= SH_IDLE;
            endcase
        end
    end

    // Line decode from the registered state.
    always_comb begin
        busy     = (state != SH_IDLE);
        ser_en_n = !busy;
        ser_clk  = (state == SH_HIGH);
        ser_data = busy && sh[GAIN_W-1];
    end

    // The serial clock only pulses inside a frame.
    assert_clk_inside_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ser_clk |-> !ser_en_n);
    // Data holds while the serial clock is high.
    assert_data_steady_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));
    // A frame only ends through the hold phase.
    assert_no_abort_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state != SH_IDLE && state != SH_HOLD) |=> (state != SH_IDLE));
endmodule

// File: rtl/gain_serial_seq.sv
// Top level of the serial gain-control update sequencer.
// Connects the register file, the stability detector and the frame generator.
// Assumes a single clock domain; only prof_pin is asynchronous.
module gain_serial_seq #(
    parameter int GAIN_W     = 8,
    parameter int ADDR_W     = 8,
    parameter int STABLE_CYC = 56,
    parameter int SETUP_CYC  = 8,
    parameter int HALF_CYC   = 4,
    parameter int HOLD_CYC   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [GAIN_W-1:0] wr_data,
    input  logic              prof_pin,
    output logic              ser_en_n,
    output logic              ser_clk,
    output logic              ser_data
);
    logic [GAIN_W-1:0] target;
    logic              start;
    logic              busy;

    gsq_regs #(.GAIN_W(GAIN_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prof_pin(prof_pin), .target(target));

    gsq_stable #(.GAIN_W(GAIN_W), .STABLE_CYC(STABLE_CYC)) u_stable (
        .clk(clk), .rst_n(rst_n), .target(target), .busy(busy), .start(start));

    gsq_shifter #(.GAIN_W(GAIN_W), .SETUP_CYC(SETUP_CYC), .HALF_CYC(HALF_CYC),
                  .HOLD_CYC(HOLD_CYC)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(start), .value(target), .busy(busy),
        .ser_en_n(ser_en_n), .ser_clk(ser_clk), .ser_data(ser_data));

    // A start is only issued while no frame is on the wire.
    assert_no_start_in_frame_R7: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> ser_en_n);
    // Every start opens a frame on the next cycle.
    assert_start_opens_frame_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> !ser_en_n);
endmodule

// File: tb/test_gain_serial_seq.sv
// Directed bench for the serial gain-control update sequencer.
module test_gain_serial_seq;
    localparam int CLK_PERIOD = 10;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       wr_en = 0;
    logic [7:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       prof_pin = 0;
    logic       ser_en_n, ser_clk, ser_data;

    int checks = 0, errors = 0, cyc = 0, wcyc = 0;
    // Frame monitor state.
    int frames = 0, f_val = 0, f_len = 0, f_start = 0, f_setup = 0, f_bits = 0;
    int start_c = 0, rise_c = 0, setup_c = 0, nbits = 0, fmt_bad = 0;
    logic [7:0] shv = 0;
    logic prev_en = 1, prev_clk = 0, prev_dat = 0;

    gain_serial_seq i_gain_serial_seq (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .prof_pin(prof_pin), .ser_en_n(ser_en_n),
        .ser_clk(ser_clk), .ser_data(ser_data));

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Decodes frames off the serial lines at the falling clock edge.
    always @(negedge clk) begin
        if (prev_en && !ser_en_n) begin
            start_c = cyc; nbits = 0; shv = 0; setup_c = -1;
        end
        if (!prev_clk && ser_clk) begin
            if (setup_c < 0) setup_c = cyc - start_c;
            shv = {shv[6:0], ser_data}; nbits++; rise_c = cyc;
        end
        if (prev_clk && !ser_clk && (cyc - rise_c) != 4) fmt_bad++;
        if (prev_clk && ser_clk && ser_data != prev_dat) fmt_bad++;
        if (!prev_en && ser_en_n) begin
            f_val = shv; f_len = cyc - start_c; f_start = start_c;
            f_setup = setup_c; f_bits = nbits; frames++;
        end
        prev_en = ser_en_n; prev_clk = ser_clk; prev_dat = ser_data;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 0; wcyc = cyc;
    endtask

    task automatic wait_frames(input int n, input string tag);
        for (int t = 0; t < 400 && frames < n; t++) @(posedge clk);
        @(posedge clk);
        chk(frames >= n, tag, frames, n);
    endtask

    task automatic quiet(input int n0, input string tag);
        repeat (160) @(posedge clk);
        chk(frames == n0, tag, frames, n0);
    endtask

    task automatic t_reset();
        int rcyc;
        repeat (4) @(negedge clk);
        rst_n = 1; rcyc = cyc;
        #1;
        chk(ser_en_n && !ser_clk && !ser_data, "R1 idle lines after reset",
            {ser_en_n, ser_clk, ser_data}, 3'b100);
        wait_frames(1, "R1 reset frame sent");
        chk(f_val == 0, "R1 reset frame value", f_val, 0);
        chk(f_start - rcyc >= 48 && f_start - rcyc <= 64, "R1 reset frame delay",
            f_start - rcyc, 56);
    endtask

    task automatic t_write();
        int n0 = frames;
        wr(8'h13, 8'hA5);
        wait_frames(n0 + 1, "R5 profile0 write frame");
        chk(f_val == 'hA5, "R5 value of profile0", f_val, 'hA5);
        chk(f_start - wcyc == 57, "R6 enable delay", f_start - wcyc, 57);
        chk(f_len == 76, "R8 enable low length", f_len, 76);
        chk(f_setup == 8, "R8 setup before first bit", f_setup, 8);
        chk(f_bits == 8, "R8 bit count", f_bits, 8);
        chk(fmt_bad == 0, "R8 clock phases and data stability", fmt_bad, 0);
        chk(f_start - wcyc + f_len <= 200, "R9 total update time",
            f_start - wcyc + f_len, 133);
    endtask

    task automatic t_profile();
        int n0 = frames;
        wr(8'h17, 8'h3C);
        quiet(n0, "R5 inactive profile write ignored");
        prof_pin = 1;
        wait_frames(n0 + 1, "R4 pin change frame");
        chk(f_val == 'h3C, "R4 pin selects profile1", f_val, 'h3C);
    endtask

    task automatic t_select();
        int n0 = frames;
        wr(8'h1F, 8'h5A);
        quiet(n0, "R5 profile3 write while profile1 active");
        wr(8'h00, 8'h02);
        wait_frames(n0 + 1, "R4 select change frame");
        chk(f_val == 'h5A, "R4 sel=2 with pin=1 gives profile3", f_val, 'h5A);
    endtask

    task automatic t_same();
        int n0 = frames;
        wr(8'h1F, 8'h5A);
        quiet(n0, "R10 same value write sends nothing");
    endtask

    task automatic t_debounce();
        int n0 = frames;
        wr(8'h1F, 8'h11);
        repeat (20) @(negedge clk);
        wr(8'h1F, 8'h22);
        wait_frames(n0 + 1, "R6 debounced frame");
        chk(f_val == 'h22, "R6 only final value sent", f_val, 'h22);
        chk(f_start - wcyc == 57, "R6 wait restarted", f_start - wcyc, 57);
        quiet(n0 + 1, "R6 single frame for two writes");
    endtask

    task automatic t_no_abort();
        int n0 = frames;
        wr(8'h1F, 8'h44);
        for (int t = 0; t < 200 && ser_en_n; t++) @(negedge clk);
        repeat (20) @(negedge clk);
        wr(8'h1F, 8'h77);
        wait_frames(n0 + 1, "R7 first frame");
        chk(f_val == 'h44 && f_len == 76, "R7 frame completed intact", f_val, 'h44);
        wait_frames(n0 + 2, "R7 deferred frame");
        chk(f_val == 'h77, "R7 deferred value", f_val, 'h77);
    endtask

    task automatic t_swreset();
        int n0 = frames;
        wr(8'h00, 8'h20);
        wait_frames(n0 + 1, "R3 soft reset frame");
        chk(f_val == 0, "R3 soft reset sends zero", f_val, 0);
        wr(8'h00, 8'h20);
        quiet(n0 + 1, "R3 no frame when already zero");
        wr(8'h17, 8'h99);
        wait_frames(n0 + 2, "R2 select cleared");
        chk(f_val == 'h99, "R2 profile1 active after select clear", f_val, 'h99);
    endtask

    initial begin
        t_reset();
        t_write();
        t_profile();
        t_select();
        t_same();
        t_debounce();
        t_no_abort();
        t_swreset();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule